// File: doc/BRIEF.md
# Single-Slope PWM Timer with Selectable Wrap Point

This block is a 16-bit up-counting timer that produces two pulse-width-modulated waveforms. It counts in one direction only. The counter advances on each cycle in which the timer-tick enable is high. It runs from zero up to a wrap value and then returns to zero, so one period lasts wrap+1 ticks. A mode input selects the wrap value. It can be one of three fixed limits (8, 9 or 10 bits wide), the active capture register, or the active compare-A register.

There are two compare channels. Each channel has a compare register and a waveform output. A two-bit output code chooses how each waveform behaves: disconnected (driven low), non-inverting, or inverting. The compare values and the capture register are written through a small write port. Each write lands in a holding register. The held value is moved to the active register only on the tick that ends a period, so a new duty cycle or a new wrap value always starts cleanly at a period boundary.

Four sticky status flags record these events:
- the wrap,
- a match on channel A,
- a match on channel B,
- a wrap taken from the capture register.

Software clears a flag by writing a one to its bit. The block contains no prescaler and no interrupt logic. Whatever is driving the block supplies the tick and consumes the flags.

Top module: `pwm_timer`

## Requirements
- R1: On a cycle with `tick_en` high in a valid mode, `count` increases by one, or becomes 0 when it already equals the wrap value. A period is therefore wrap+1 ticks long. When `tick_en` is low, `count` does not change.
- R2: Mode code 5 wraps at 0x00FF, mode code 6 wraps at 0x01FF and mode code 7 wraps at 0x03FF.
- R3: Mode code 14 wraps at the active capture value and mode code 15 wraps at the active compare-A value. The smallest wrap value that is meaningful is 0x0003.
- R4: Any mode code other than 5, 6, 7, 14 or 15 forces `count` to 0 on every cycle. In such a mode, every active register is loaded from its holding register on every cycle. Waveform state and flags are left unchanged.
- R5: Output code 2 (non-inverting) drives the waveform high on the tick where `count` equals the channel's compare value, and low on the tick where `count` equals the wrap value. When both happen on the same tick, the wrap action wins.
- R6: Output code 3 (inverting) drives the waveform low on a compare match and high on the wrap tick. When both happen on the same tick, the wrap action wins.
- R7: Output codes 0 and 1 hold the waveform output low.
- R8: The overflow flag (bit 0) is set after each tick in which `count` equals the wrap value. The capture flag (bit 3) is set on that same tick, but only when the mode code is 14.
- R9: The compare-A flag (bit 1) and the compare-B flag (bit 2) are set after each tick in which `count` equals that channel's active compare value.
- R10: A write to address 0 (compare A), address 1 (compare B) or address 2 (capture) goes to a holding register. In a valid mode, the held value becomes active only on a tick where `count` equals the wrap value.
- R11: A write to address 3 clears each flag whose bit is one in `wr_data[3:0]`. If a flag is set and cleared on the same cycle, the set wins.
- R12: Reset leaves `count` at 0, both waveforms low and all flags clear. Reset also sets every holding and active register to 0xFFFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | Timer tick; the counter and outputs advance only when high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 compare A, 1 compare B, 2 capture, 3 flag clear |
| wr_data | input | 16 | Write data |
| mode | input | 4 | Wrap-value select (5, 6, 7, 14, 15 valid) |
| out_mode_a | input | 2 | Output code of channel A |
| out_mode_b | input | 2 | Output code of channel B |
| wave_a | output | 1 | Waveform output of channel A |
| wave_b | output | 1 | Waveform output of channel B |
| count | output | 16 | Current counter value |
| flag_ovf | output | 1 | Sticky wrap flag |
| flag_cmp_a | output | 1 | Sticky compare-A match flag |
| flag_cmp_b | output | 1 | Sticky compare-B match flag |
| flag_cap | output | 1 | Sticky capture-wrap flag |

## Verification
The assertions watch several relations on every cycle:
- the return to zero after the wrap value,
- the frozen counter on idle ticks and the cleared counter in invalid modes,
- the overflow and compare-A flags rising after their events, and the capture flag rising only in mode 14,
- the wrap-tick level of channel A in both output styles,
- the rule that the active capture value changes only at a period boundary or while stopped.

Other behaviours only the bench's scenarios can show, because they span many cycles or need a reference model:
- the waveform shape over whole periods,
- the exact lengths of the fixed wrap limits,
- the delay of a buffered wrap change until the current period ends,
- set-versus-clear priority on the flags,
- the outputs staying low under codes 0 and 1.

// File: rtl/pwm_timer_pkg.sv
// Package: constants shared by the PWM timer and its checker.
// Assumes a counter width of at least 10 bits so the fixed limits fit.
package pwm_timer_pkg;

    // Mode codes that select the wrap value
    localparam logic [3:0] MODE_FIX8  = 4'd5;
    localparam logic [3:0] MODE_FIX9  = 4'd6;
    localparam logic [3:0] MODE_FIX10 = 4'd7;
    localparam logic [3:0] MODE_CAP   = 4'd14;
    localparam logic [3:0] MODE_CMPA  = 4'd15;

    // Fixed wrap limits
    localparam int unsigned TOP_FIX8  = 255;
    localparam int unsigned TOP_FIX9  = 511;
    localparam int unsigned TOP_FIX10 = 1023;

    // Register slots behind the write port
    localparam int NUM_CH        = 2;
    localparam int NUM_SHADOW    = 3;
    localparam int SH_CMP_A      = 0;
    localparam int SH_CMP_B      = 1;
    localparam int SH_CAP        = 2;
    localparam int ADDR_FLAG_CLR = 3;

    // Flag bit positions
    localparam int FLAG_W  = 4;
    localparam int FL_OVF  = 0;
    localparam int FL_CMPA = 1;
    localparam int FL_CMPB = 2;
    localparam int FL_CAP  = 3;

    // Waveform output codes
    typedef enum logic [1:0] {
        OUT_OFF0   = 2'd0,
        OUT_OFF1   = 2'd1,
        OUT_NONINV = 2'd2,
        OUT_INV    = 2'd3
    } wave_code_e;

endpackage

// File: rtl/pwm_shadow_reg.sv
// Double-buffered register.
// A write lands in the holding stage; the active stage copies the holding
// stage when 'load' is high. Assumes write and load may coincide, in which
// case the active stage receives the previous holding value.
module pwm_shadow_reg #(
    parameter int          W       = 16,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         load,
    output logic [W-1:0] act_q
);

    logic [W-1:0] hold_q;

    // Capture software writes into the holding stage
    always_ff @(posedge clk) begin
        if (!rst_n)     hold_q <= RST_VAL;
        else if (wr_en) hold_q <= wr_data;
    end

    // Transfer the holding stage to the active stage on request
    always_ff @(posedge clk) begin
        if (!rst_n)    act_q <= RST_VAL;
        else if (load) act_q <= hold_q;
    end

endmodule

// File: rtl/pwm_counter.sv
// Single-slope up counter.
// Counts from zero to 'top' on ticks and returns to zero on the tick after.
// A low 'run_ok' (invalid mode) forces the count to zero.
// Assumes 'top' is stable during a tick except at period boundaries.
module pwm_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick_en,
    input  logic         run_ok,
    input  logic [W-1:0] top,
    output logic [W-1:0] count,
    output logic         at_top
);

    // Flag the last count of the period
    always_comb at_top = (count == top);

    // Advance, wrap or clear the count
    always_ff @(posedge clk) begin
        if (!rst_n)       count <= '0;
        else if (!run_ok) count <= '0;
        else if (tick_en) count <= at_top ? '0 : count + 1'b1;
    end

endmodule

// File: rtl/pwm_channel.sv
// One compare channel.
// Detects a match against the active compare value and keeps the waveform
// level. The two-bit code picks the style:
//   bit 1 connects the output,
//   bit 0 gives the level taken at the wrap (the match level is its inverse).
// On a tick where wrap and match coincide, the wrap action wins.
module pwm_channel #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step,
    input  logic         at_top,
    input  logic [W-1:0] count,
    input  logic [W-1:0] cmp,
    input  logic [1:0]   code,
    output logic         match,
    output logic         wave
);

    logic level_q;

    // Compare the count with the active compare value
    always_comb match = (count == cmp);

    // Update the waveform level on ticks at the wrap or on a match
    always_ff @(posedge clk) begin
        if (!rst_n)      level_q <= 1'b0;
        else if (step) begin
            if (at_top)     level_q <= code[0];
            else if (match) level_q <= ~code[0];
        end
    end

    // Drive the pin only when the code connects it
    always_comb wave = code[1] & level_q;

endmodule

// File: rtl/pwm_timer.sv
// Single-slope PWM timer with a wrap point selected by mode.
// Contents:
//   three double-buffered registers (compare A, compare B, capture),
//   the counter,
//   two compare channels,
//   four sticky flags cleared by writing ones.
// Assumes tick_en comes from an external prescaler and a register write
// lasts one cycle.
module pwm_timer
    import pwm_timer_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    input  logic [3:0]        mode,
    input  logic [1:0]        out_mode_a,
    input  logic [1:0]        out_mode_b,
    output logic              wave_a,
    output logic              wave_b,
    output logic [CNT_W-1:0]  count,
    output logic              flag_ovf,
    output logic              flag_cmp_a,
    output logic              flag_cmp_b,
    output logic              flag_cap
);

    logic [CNT_W-1:0]  act_val [NUM_SHADOW];
    logic [CNT_W-1:0]  top_val;
    logic              run_ok;
    logic              at_top;
    logic              step;
    logic              shadow_load;
    logic [1:0]        ch_code [NUM_CH];
    logic [NUM_CH-1:0] ch_match;
    logic [NUM_CH-1:0] ch_wave;
    logic [FLAG_W-1:0] flag_set;
    logic [FLAG_W-1:0] flag_clr;
    logic [FLAG_W-1:0] flag_q;
    logic [CNT_W-1:0]  cap_act;
    logic [CNT_W-1:0]  cmpa_act;

    // Select the wrap value and decide whether the mode is valid
    always_comb begin
        run_ok  = 1'b1;
        top_val = '0;
        unique case (mode)
            MODE_FIX8:  top_val = CNT_W'(TOP_FIX8);
            MODE_FIX9:  top_val = CNT_W'(TOP_FIX9);
            MODE_FIX10: top_val = CNT_W'(TOP_FIX10);
            MODE_CAP:   top_val = act_val[SH_CAP];
            MODE_CMPA:  top_val = act_val[SH_CMP_A];
            default:    run_ok  = 1'b0;
        endcase
    end

    // A tick that counts, and the moment buffered values take effect
    always_comb begin
        step        = tick_en & run_ok;
        shadow_load = (step & at_top) | ~run_ok;
    end

    // Double-buffered compare and capture registers
    for (genvar gi = 0; gi < NUM_SHADOW; gi++) begin : g_shadow
        pwm_shadow_reg #(
            .W       (CNT_W),
            .RST_VAL ({CNT_W{1'b1}})
        ) u_shadow (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (wr_en && (wr_addr == ADDR_W'(gi))),
            .wr_data (wr_data),
            .load    (shadow_load),
            .act_q   (act_val[gi])
        );
    end

    // Named taps of the active values, used by the checker
    always_comb begin
        cap_act  = act_val[SH_CAP];
        cmpa_act = act_val[SH_CMP_A];
    end

    // Counter
    pwm_counter #(
        .W (CNT_W)
    ) u_counter (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_en (tick_en),
        .run_ok  (run_ok),
        .top     (top_val),
        .count   (count),
        .at_top  (at_top)
    );

    // Route the output codes to their channels
    always_comb begin
        ch_code[0] = out_mode_a;
        ch_code[1] = out_mode_b;
    end

    // Compare channels; channel i uses active register i
    for (genvar gc = 0; gc < NUM_CH; gc++) begin : g_chan
        pwm_channel #(
            .W (CNT_W)
        ) u_chan (
            .clk    (clk),
            .rst_n  (rst_n),
            .step   (step),
            .at_top (at_top),
            .count  (count),
            .cmp    (act_val[gc]),
            .code   (ch_code[gc]),
            .match  (ch_match[gc]),
            .wave   (ch_wave[gc])
        );
    end

    // Gather the flag set and clear requests
    always_comb begin
        flag_set          = '0;
        flag_set[FL_OVF]  = step & at_top;
        flag_set[FL_CMPA] = step & ch_match[0];
        flag_set[FL_CMPB] = step & ch_match[1];
        flag_set[FL_CAP]  = step & at_top & (mode == MODE_CAP);
        flag_clr = (wr_en && (wr_addr == ADDR_W'(ADDR_FLAG_CLR)))
                 ? wr_data[FLAG_W-1:0] : '0;
    end

    // Sticky flags; a set beats a clear on the same cycle
    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= '0;
        else        flag_q <= flag_set | (flag_q & ~flag_clr);
    end

    // Drive the outputs
    always_comb begin
        wave_a     = ch_wave[0];
        wave_b     = ch_wave[1];
        flag_ovf   = flag_q[FL_OVF];
        flag_cmp_a = flag_q[FL_CMPA];
        flag_cmp_b = flag_q[FL_CMPB];
        flag_cap   = flag_q[FL_CAP];
    end

endmodule

// File: rtl/pwm_timer_chk.sv
// Checker for pwm_timer, bound to every instance.
// Recomputes the wrap value from the mode and the active registers, and
// checks timing relations on the counter, the flags and channel A.
module pwm_timer_chk
    import pwm_timer_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick_en,
    input logic [3:0]       mode,
    input logic [CNT_W-1:0] count,
    input logic [CNT_W-1:0] cap_act,
    input logic [CNT_W-1:0] cmpa_act,
    input logic [1:0]       out_mode_a,
    input logic             wave_a,
    input logic             flag_ovf,
    input logic             flag_cmp_a,
    input logic             flag_cap
);

    logic             valid_c;
    logic [CNT_W-1:0] top_c;
    logic             wrap_c;

    // Independent view of the wrap value
    always_comb begin
        valid_c = (mode == MODE_FIX8) || (mode == MODE_FIX9) || (mode == MODE_FIX10)
               || (mode == MODE_CAP)  || (mode == MODE_CMPA);
        top_c = (mode == MODE_FIX8)  ? CNT_W'(TOP_FIX8)  :
                (mode == MODE_FIX9)  ? CNT_W'(TOP_FIX9)  :
                (mode == MODE_FIX10) ? CNT_W'(TOP_FIX10) :
                (mode == MODE_CAP)   ? cap_act : cmpa_act;
        wrap_c = tick_en && valid_c && (count == top_c);
    end

    assert_wrap_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_c |=> (count == '0));

    assert_idle_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_en && valid_c) |=> $stable(count));

    assert_stop_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_c |=> (count == '0));

    assert_noninv_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap_c && out_mode_a == 2'd2) |=> (out_mode_a != 2'd2 || !wave_a));

    assert_inv_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap_c && out_mode_a == 2'd3) |=> (out_mode_a != 2'd3 || wave_a));

    assert_ovf_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_c |=> flag_ovf);

    assert_cap_only_mode14_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_cap) |-> ($past(mode) == MODE_CAP));

    assert_cmpa_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && valid_c && count == cmpa_act) |=> flag_cmp_a);

    assert_buffered_cap_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cap_act) |-> ($past(wrap_c) || $past(!valid_c)));

endmodule

bind pwm_timer pwm_timer_chk #(.CNT_W(CNT_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_en    (tick_en),
    .mode       (mode),
    .count      (count),
    .cap_act    (cap_act),
    .cmpa_act   (cmpa_act),
    .out_mode_a (out_mode_a),
    .wave_a     (wave_a),
    .flag_ovf   (flag_ovf),
    .flag_cmp_a (flag_cmp_a),
    .flag_cap   (flag_cap)
);

// File: tb/pwm_timer_tb_top.sv
// Scoreboard bench for pwm_timer.
// The driver applies one cycle of stimulus at each falling edge. It updates a
// model written from the requirements and queues the expected result. The
// monitor pops one item after each rising edge and compares it.
module pwm_timer_tb_top;

    typedef struct {
        logic [15:0] cnt;
        logic        wa;
        logic        wb;
        logic [3:0]  fl;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [3:0]  mode = '0;
    logic [1:0]  out_mode_a = '0;
    logic [1:0]  out_mode_b = '0;
    logic        wave_a, wave_b, flag_ovf, flag_cmp_a, flag_cmp_b, flag_cap;
    logic [15:0] count;

    int checks = 0;
    int errors = 0;
    exp_t q[$];

    // Bench-side settings and the reference model
    logic [3:0]  b_mode = '0;
    logic [1:0]  b_coma = '0;
    logic [1:0]  b_comb = '0;
    string       cur_tag = "R12";
    logic [15:0] m_cnt = '0;
    logic [15:0] m_hold [3];
    logic [15:0] m_act [3];
    logic        m_la = 1'b0;
    logic        m_lb = 1'b0;
    logic [3:0]  m_fl = '0;

    always #5 clk = ~clk;

    pwm_timer dut_i (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .mode(mode),
        .out_mode_a(out_mode_a), .out_mode_b(out_mode_b),
        .wave_a(wave_a), .wave_b(wave_b), .count(count),
        .flag_ovf(flag_ovf), .flag_cmp_a(flag_cmp_a),
        .flag_cmp_b(flag_cmp_b), .flag_cap(flag_cap)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Driver: apply one cycle of stimulus, advance the model, queue the result
    task automatic drive(input bit tk, input bit we, input logic [1:0] ad, input logic [15:0] dt);
        bit          valid;
        logic [15:0] top;
        bit          wrap, ma, mb;
        logic [3:0]  set, clr;
        exp_t        e;
        @(negedge clk);
        tick_en = tk; wr_en = we; wr_addr = ad; wr_data = dt;
        mode = b_mode; out_mode_a = b_coma; out_mode_b = b_comb;
        valid = 1'b1;
        case (b_mode)
            4'd5:    top = 16'h00FF;
            4'd6:    top = 16'h01FF;
            4'd7:    top = 16'h03FF;
            4'd14:   top = m_act[2];
            4'd15:   top = m_act[0];
            default: begin top = '0; valid = 1'b0; end
        endcase
        wrap = valid && tk && (m_cnt == top);
        ma = valid && tk && (m_cnt == m_act[0]);
        mb = valid && tk && (m_cnt == m_act[1]);
        set = {wrap && (b_mode == 4'd14), mb, ma, wrap};
        clr = (we && ad == 2'd3) ? dt[3:0] : 4'h0;
        if (valid && tk) begin
            if (wrap)    m_la = b_coma[0];
            else if (ma) m_la = ~b_coma[0];
            if (wrap)    m_lb = b_comb[0];
            else if (mb) m_lb = ~b_comb[0];
        end
        m_fl = set | (m_fl & ~clr);
        if (!valid)         m_cnt = '0;
        else if (tk)        m_cnt = wrap ? 16'h0 : m_cnt + 16'h1;
        if (!valid || wrap) for (int i = 0; i < 3; i++) m_act[i] = m_hold[i];
        if (we && ad != 2'd3) m_hold[ad] = dt;
        e.cnt = m_cnt;
        e.wa = b_coma[1] & m_la;
        e.wb = b_comb[1] & m_lb;
        e.fl = m_fl;
        e.tag = cur_tag;
        q.push_back(e);
    endtask

    task automatic run(input int n, input bit tk);
        for (int i = 0; i < n; i++) drive(tk, 1'b0, 2'd0, 16'h0);
    endtask

    // Monitor: compare the design against the queued expectation
    always @(posedge clk) begin
        #2;
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            check({count, wave_a, wave_b, flag_cap, flag_cmp_b, flag_cmp_a, flag_ovf}
                  === {e.cnt, e.wa, e.wb, e.fl}, e.tag,
                  {10'h0, count, wave_a, wave_b, flag_cap, flag_cmp_b, flag_cmp_a, flag_ovf},
                  {10'h0, e.cnt, e.wa, e.wb, e.fl});
        end
    end

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 3; i++) begin m_hold[i] = 16'hFFFF; m_act[i] = 16'hFFFF; end
        repeat (3) @(negedge clk);
        // R12: reset state at the ports
        check(count == 16'h0, "R12", {16'h0, count}, 32'h0);
        check({wave_a, wave_b} == 2'b00, "R12", {30'h0, wave_a, wave_b}, 32'h0);
        check({flag_cap, flag_cmp_b, flag_cmp_a, flag_ovf} == 4'h0, "R12",
              {28'h0, flag_cap, flag_cmp_b, flag_cmp_a, flag_ovf}, 32'h0);
        rst_n = 1'b1;

        // R4: stopped mode keeps the count at 0 and loads the buffers directly
        cur_tag = "R4";
        drive(1'b1, 1'b1, 2'd0, 16'd2);
        drive(1'b1, 1'b1, 2'd1, 16'd4);
        drive(1'b1, 1'b1, 2'd2, 16'd5);
        run(3, 1'b1);

        // R5 and R6: capture-defined wrap, non-inverting A, inverting B
        b_mode = 4'd14; b_coma = 2'd2; b_comb = 2'd3;
        cur_tag = "R5"; run(6, 1'b1);
        cur_tag = "R6"; run(6, 1'b1);
        cur_tag = "R8"; run(6, 1'b1);
        cur_tag = "R9"; run(6, 1'b1);

        // R1: idle ticks hold everything, then counting resumes
        cur_tag = "R1";
        run(4, 1'b0);
        run(4, 1'b1);

        // R10: a new capture value waits for the end of the period
        cur_tag = "R10";
        drive(1'b1, 1'b1, 2'd2, 16'd3);
        run(12, 1'b1);

        // R11: write-one clears, including clears colliding with new events
        cur_tag = "R11";
        drive(1'b0, 1'b1, 2'd3, 16'h000F);
        drive(1'b0, 1'b1, 2'd3, 16'h0001);
        for (int i = 0; i < 6; i++) drive(1'b1, 1'b1, 2'd3, 16'h000F);
        run(4, 1'b1);

        // R3: compare-A defined wrap; the capture flag stays clear
        cur_tag = "R3";
        drive(1'b0, 1'b1, 2'd3, 16'h000F);
        b_mode = 4'd0;
        drive(1'b1, 1'b1, 2'd0, 16'd7);
        drive(1'b1, 1'b0, 2'd0, 16'd0);
        b_mode = 4'd15; b_coma = 2'd3; b_comb = 2'd2;
        run(20, 1'b1);

        // R7: disconnected codes keep both outputs low
        cur_tag = "R7";
        b_coma = 2'd0; b_comb = 2'd1;
        run(12, 1'b1);

        // R2: fixed wrap limits
        cur_tag = "R2";
        b_coma = 2'd2; b_comb = 2'd3;
        b_mode = 4'd0; drive(1'b1, 1'b1, 2'd0, 16'd100);
        drive(1'b1, 1'b1, 2'd1, 16'd300);
        b_mode = 4'd5; run(260, 1'b1);
        b_mode = 4'd0; run(1, 1'b1);
        b_mode = 4'd6; run(516, 1'b1);
        b_mode = 4'd0; run(1, 1'b1);
        b_mode = 4'd7; run(1030, 1'b1);

        repeat (3) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule